// File: doc/BRIEF.md
# SPI Target with Dual Byte FIFOs

This block is the target (slave) end of an SPI link. Bits arriving on the data-in line are assembled into bytes and stored in a 1024-byte receive FIFO. Bytes for the controller are taken from a separate 1024-byte transmit FIFO and shifted out on the data-out line. Each FIFO keeps an 11-bit write pointer and an 11-bit read pointer. The low ten bits index the buffer. The top bit flips on every pass through the buffer, and that bit is what tells a full FIFO from an empty one.

The block owns the receive write pointer and the transmit read pointer. Local logic owns the other two pointers and sets them with plain strobe-and-value pins. Local logic fills the transmit buffer with whole 32-bit words, reads received bytes by buffer address, and controls both directions with one command strobe. SPI mode and per-direction bit order are static configuration inputs.

The byte sent when no real data can go out comes from a programmable fill register. Sticky event flags record CS edges, transmit underrun and receive overflow. A level interrupt reports when enough received bytes are waiting. The data paths are pointer-based memories rather than streams, so no valid/ready handshake is used. Every host strobe takes effect on the clock edge where it is high, and the block never stalls one.

Top module: `spi_target_dualfifo`

## Requirements
- R1: After reset, all four pointers are 0, both directions are disabled, all event flags are 0, and the fill byte is 0xFF.
- R2: With receive enabled, the 8th sampling edge inside a CS-low period completes a byte. The byte is stored at index rx_wptr[9:0] and rx_wptr then advances by 1 modulo 2048. With MSB-first order the first bit received becomes bit 7. With cfg_rx_lsb_first set, the first bit received becomes bit 0.
- R3: When a byte completes while the receive FIFO is full (rx_wptr[9:0]==rx_rptr[9:0] and the top bits differ), the byte is dropped, rx_wptr is unchanged, and overflow flag bit 3 is set.
- R4: Writing a word at word index k fills buffer bytes 4k..4k+3, with data[7:0] at byte 4k. Bytes leave in read-pointer order, MSB first unless cfg_tx_lsb_first is set. With cpha=0, the next byte is fetched at the trailing edge that ends the current byte, even if CS then rises.
- R5: While transmit is disabled, the data-out line carries the fill byte and tx_rptr does not move.
- R6: When transmit is enabled and the transmit FIFO is empty at the start of a byte, the fill byte is sent and underrun flag bit 2 is set.
- R7: cfg_cpol is the idle clock level. With cpha=0, data is sampled on the leading edge and the first bit is on the line from the moment CS falls. With cpha=1, data changes on the leading edge and is sampled on the trailing edge.
- R8: rx_level_irq is high exactly when rx_level_ie is 1 and (rx_wptr - rx_rptr) mod 2048 >= rx_threshold.
- R9: A falling CS sets flag bit 0 and a rising CS sets flag bit 1. Each flag stays set until the matching evt_clr bit is written 1. evt_irq is the OR of (flag bits [1:0] AND evt_ie).
- R10: Command bits are: bit0 TX pointer clear, bit1 TX enable, bit2 TX disable, bit3 RX pointer clear, bit4 RX enable, bit5 RX disable. A clear zeroes only that direction's two pointers. Disable wins over enable when both are written together.
- R11: When CS rises before a byte is complete, the partial bits are discarded and the next transfer starts a fresh byte.
- R12: A write to the TX write pointer or the RX read pointer sets that pointer to the value written. This changes the FIFO occupancy seen by the data path and by the level interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from controller |
| spi_miso | output | 1 | Serial data to controller |
| cfg_cpol | input | 1 | Idle clock level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_tx_lsb_first | input | 1 | Send LSB first |
| cfg_rx_lsb_first | input | 1 | Receive LSB first |
| fill_we | input | 1 | Load fill byte |
| fill_wdata | input | 8 | New fill byte |
| fifo_cmd_we | input | 1 | Command strobe |
| fifo_cmd | input | 6 | Command bits (R10) |
| tx_en | output | 1 | Transmit enabled |
| rx_en | output | 1 | Receive enabled |
| tx_word_we | input | 1 | Transmit word write strobe |
| tx_word_idx | input | 8 | Word index into transmit buffer |
| tx_word_data | input | 32 | Word data, little-endian bytes |
| tx_wptr_we | input | 1 | Set TX write pointer |
| tx_wptr_wdata | input | 11 | New TX write pointer |
| rx_rptr_we | input | 1 | Set RX read pointer |
| rx_rptr_wdata | input | 11 | New RX read pointer |
| tx_wptr | output | 11 | TX write pointer |
| tx_rptr | output | 11 | TX read pointer |
| rx_wptr | output | 11 | RX write pointer |
| rx_rptr | output | 11 | RX read pointer |
| rx_rd_addr | input | 10 | Receive buffer read index |
| rx_rd_data | output | 8 | Receive buffer byte at that index |
| rx_threshold | input | 11 | Level interrupt threshold |
| rx_level_ie | input | 1 | Level interrupt enable |
| rx_level_irq | output | 1 | Level interrupt |
| evt_ie | input | 2 | CS-assert / CS-deassert interrupt enables |
| evt_clr | input | 4 | Write-1 clear for event flags |
| evt_flags | output | 4 | {overflow, underrun, CS-deassert, CS-assert} |
| evt_irq | output | 1 | CS event interrupt |

## Verification
The hardest state to reach from the ports is a full receive FIFO. Getting there over the serial line would take 1024 bytes. The bench instead sets the receive read pointer to the current write pointer with the top bit flipped, which makes the FIFO full in one write. It then clocks in one more byte and checks that the byte is dropped and the overflow flag is set. A second awkward case is a CS edge that lands in the middle of a byte. The bench reaches it with a transfer that stops after four clock pulses, then checks that the next complete byte arrives intact.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  localparam int CMD_TX_CLR = 0;
  localparam int CMD_TX_EN  = 1;
  localparam int CMD_TX_DIS = 2;
  localparam int CMD_RX_CLR = 3;
  localparam int CMD_RX_EN  = 4;
  localparam int CMD_RX_DIS = 5;
  localparam int FLG_CSA  = 0;
  localparam int FLG_CSD  = 1;
  localparam int FLG_UNDR = 2;
  localparam int FLG_OVF  = 3;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[s] <= RST_VAL;
        else        st[s] <= d_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[s] <= RST_VAL;
        else        st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_tgt_fifo.sv
module spi_tgt_fifo #(
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1,
  localparam int WIDX_W = IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [7:0]        push_data,
  input  logic              word_we,
  input  logic [WIDX_W-1:0] word_idx,
  input  logic [31:0]       word_data,
  input  logic              wptr_we,
  input  logic [PTR_W-1:0]  wptr_val,
  input  logic              rptr_we,
  input  logic [PTR_W-1:0]  rptr_val,
  input  logic              pop,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [7:0]        rd_data,
  output logic [PTR_W-1:0]  wptr,
  output logic [PTR_W-1:0]  rptr
);
  logic [7:0] mem [DEPTH];
  logic full, empty;

  assign empty = (wptr == rptr);
  assign full  = (wptr[IDX_W-1:0] == rptr[IDX_W-1:0]) && (wptr[IDX_W] != rptr[IDX_W]);
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr[IDX_W-1:0]] <= push_data;
    if (word_we)
      for (int b = 0; b < 4; b++) mem[{word_idx, 2'(b)}] <= word_data[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wptr_we)           wptr <= wptr_val;
      else if (push && !full) wptr <= wptr + PTR_W'(1);
      if (rptr_we)            rptr <= rptr_val;
      else if (pop && !empty) rptr <= rptr + PTR_W'(1);
    end
  end

  p_push_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !clr && !wptr_we) |=> wptr == $past(wptr) + PTR_W'(1));
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clr && !wptr_we) |=> wptr == $past(wptr));
  p_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !clr && !rptr_we) |=> rptr == $past(rptr));
  p_clr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wptr == '0 && rptr == '0));
endmodule

// File: rtl/spi_tgt_serdes.sv
module spi_tgt_serdes
  import spi_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       rx_lsb,
  input  logic       tx_lsb,
  input  logic [7:0] tx_byte,
  output logic       tx_take,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       cs_fall,
  output logic       cs_rise
);
  logic sclk_s, cs_s, mosi_s, sclk_q, cs_q;
  logic active, toggled, lead, trail, sample, shift, load_now;
  logic [2:0] rx_cnt, tx_cnt;
  logic [7:0] rx_sr, tx_sr, rx_next;

  spi_tgt_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({spi_sclk, spi_cs_n, spi_mosi}),
    .q({sclk_s, cs_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
    end

  assign active   = !cs_s;
  assign toggled  = sclk_s ^ sclk_q;
  assign lead     = active && toggled && (sclk_s != cpol);
  assign trail    = active && toggled && (sclk_s == cpol);
  assign sample   = cpha ? trail : lead;
  assign shift    = cpha ? lead : trail;
  assign cs_fall  = cs_q && !cs_s;
  assign cs_rise  = !cs_q && cs_s;
  assign load_now = (cs_fall && !cpha) || (shift && tx_cnt == 3'd0);
  assign tx_take  = load_now;
  assign rx_next  = {rx_sr[6:0], mosi_s};
  assign spi_miso = tx_sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt <= '0; tx_cnt <= '0; rx_sr <= '0; tx_sr <= 8'hFF;
      rx_valid <= 1'b0; rx_data <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!active) begin
        rx_cnt <= '0;
        tx_cnt <= '0;
      end else begin
        if (sample) begin
          rx_sr  <= rx_next;
          rx_cnt <= rx_cnt + 3'd1;
          if (rx_cnt == 3'd7) begin
            rx_valid <= 1'b1;
            rx_data  <= rx_lsb ? rev8(rx_next) : rx_next;
          end
        end
        if (load_now) begin
          tx_sr  <= tx_lsb ? rev8(tx_byte) : tx_byte;
          tx_cnt <= 3'd1;
        end else if (shift) begin
          tx_sr  <= {tx_sr[6:0], 1'b0};
          tx_cnt <= tx_cnt + 3'd1;
        end
      end
    end
  end

  p_partial_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !rx_valid);
endmodule

// File: rtl/spi_target_dualfifo.sv
module spi_target_dualfifo
  import spi_tgt_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1,
  localparam int WIDX_W = IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_tx_lsb_first,
  input  logic              cfg_rx_lsb_first,
  input  logic              fill_we,
  input  logic [7:0]        fill_wdata,
  input  logic              fifo_cmd_we,
  input  logic [5:0]        fifo_cmd,
  output logic              tx_en,
  output logic              rx_en,
  input  logic              tx_word_we,
  input  logic [WIDX_W-1:0] tx_word_idx,
  input  logic [31:0]       tx_word_data,
  input  logic              tx_wptr_we,
  input  logic [PTR_W-1:0]  tx_wptr_wdata,
  input  logic              rx_rptr_we,
  input  logic [PTR_W-1:0]  rx_rptr_wdata,
  output logic [PTR_W-1:0]  tx_wptr,
  output logic [PTR_W-1:0]  tx_rptr,
  output logic [PTR_W-1:0]  rx_wptr,
  output logic [PTR_W-1:0]  rx_rptr,
  input  logic [IDX_W-1:0]  rx_rd_addr,
  output logic [7:0]        rx_rd_data,
  input  logic [PTR_W-1:0]  rx_threshold,
  input  logic              rx_level_ie,
  output logic              rx_level_irq,
  input  logic [1:0]        evt_ie,
  input  logic [3:0]        evt_clr,
  output logic [3:0]        evt_flags,
  output logic              evt_irq
);
  logic [7:0] fill_byte, tx_head, tx_byte, rx_data;
  logic tx_clr, rx_clr, tx_take, tx_pop, tx_empty, rx_full, rx_valid, rx_push;
  logic cs_fall, cs_rise;
  logic [3:0] evt_set;
  logic [PTR_W-1:0] rx_level;

  assign tx_clr   = fifo_cmd_we && fifo_cmd[CMD_TX_CLR];
  assign rx_clr   = fifo_cmd_we && fifo_cmd[CMD_RX_CLR];
  assign tx_empty = (tx_wptr == tx_rptr);
  assign rx_full  = (rx_wptr[IDX_W-1:0] == rx_rptr[IDX_W-1:0]) && (rx_wptr[IDX_W] != rx_rptr[IDX_W]);
  assign tx_byte  = (tx_en && !tx_empty) ? tx_head : fill_byte;
  assign tx_pop   = tx_take && tx_en;
  assign rx_push  = rx_valid && rx_en;
  assign rx_level = rx_wptr - rx_rptr;
  assign rx_level_irq = rx_level_ie && (rx_level >= rx_threshold);
  assign evt_irq  = |(evt_flags[1:0] & evt_ie);

  assign evt_set[FLG_CSA]  = cs_fall;
  assign evt_set[FLG_CSD]  = cs_rise;
  assign evt_set[FLG_UNDR] = tx_take && tx_en && tx_empty;
  assign evt_set[FLG_OVF]  = rx_push && rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_byte <= 8'hFF;
      tx_en     <= 1'b0;
      rx_en     <= 1'b0;
      evt_flags <= '0;
    end else begin
      if (fill_we) fill_byte <= fill_wdata;
      if (fifo_cmd_we) begin
        if (fifo_cmd[CMD_TX_DIS])     tx_en <= 1'b0;
        else if (fifo_cmd[CMD_TX_EN]) tx_en <= 1'b1;
        if (fifo_cmd[CMD_RX_DIS])     rx_en <= 1'b0;
        else if (fifo_cmd[CMD_RX_EN]) rx_en <= 1'b1;
      end
      evt_flags <= (evt_flags & ~evt_clr) | evt_set;
    end
  end

  spi_tgt_serdes u_serdes (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .rx_lsb(cfg_rx_lsb_first), .tx_lsb(cfg_tx_lsb_first),
    .tx_byte(tx_byte), .tx_take(tx_take), .rx_valid(rx_valid), .rx_data(rx_data),
    .cs_fall(cs_fall), .cs_rise(cs_rise)
  );

  spi_tgt_fifo #(.DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(1'b0), .push_data(8'h00),
    .word_we(tx_word_we), .word_idx(tx_word_idx), .word_data(tx_word_data),
    .wptr_we(tx_wptr_we), .wptr_val(tx_wptr_wdata),
    .rptr_we(1'b0), .rptr_val('0),
    .pop(tx_pop), .rd_addr(tx_rptr[IDX_W-1:0]), .rd_data(tx_head),
    .wptr(tx_wptr), .rptr(tx_rptr)
  );

  spi_tgt_fifo #(.DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(rx_push), .push_data(rx_data),
    .word_we(1'b0), .word_idx('0), .word_data(32'h0),
    .wptr_we(1'b0), .wptr_val('0),
    .rptr_we(rx_rptr_we), .rptr_val(rx_rptr_wdata),
    .pop(1'b0), .rd_addr(rx_rd_addr), .rd_data(rx_rd_data),
    .wptr(rx_wptr), .rptr(rx_rptr)
  );

  p_tx_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !tx_clr) |=> tx_rptr == $past(tx_rptr));
  p_undr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flags[FLG_UNDR] && !evt_clr[FLG_UNDR]) |=> evt_flags[FLG_UNDR]);
  p_cs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> evt_flags[FLG_CSA]);
  p_dis_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cmd_we && fifo_cmd[CMD_TX_DIS]) |=> !tx_en);
endmodule

// File: tb/spi_target_dualfifo_tb.sv
module spi_target_dualfifo_tb;
  localparam int H = 8;
  logic clk = 0, rst_n = 0;
  logic spi_sclk = 0, spi_cs_n = 1, spi_mosi = 0, spi_miso;
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_tx_lsb_first = 0, cfg_rx_lsb_first = 0;
  logic fill_we = 0; logic [7:0] fill_wdata = 0;
  logic fifo_cmd_we = 0; logic [5:0] fifo_cmd = 0;
  logic tx_en, rx_en;
  logic tx_word_we = 0; logic [7:0] tx_word_idx = 0; logic [31:0] tx_word_data = 0;
  logic tx_wptr_we = 0; logic [10:0] tx_wptr_wdata = 0;
  logic rx_rptr_we = 0; logic [10:0] rx_rptr_wdata = 0;
  logic [10:0] tx_wptr, tx_rptr, rx_wptr, rx_rptr;
  logic [9:0] rx_rd_addr = 0; logic [7:0] rx_rd_data;
  logic [10:0] rx_threshold = 11'd1; logic rx_level_ie = 0, rx_level_irq;
  logic [1:0] evt_ie = 0; logic [3:0] evt_clr = 0, evt_flags; logic evt_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_target_dualfifo u_dut (.*);

  function automatic logic [7:0] flip(input logic [7:0] b);
    for (int i = 0; i < 8; i++) flip[i] = b[7-i];
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic cmd(input logic [5:0] c);
    fifo_cmd = c; fifo_cmd_we = 1; tick(); fifo_cmd_we = 0; tick();
  endtask
  task automatic wr_word(input logic [7:0] k, input logic [31:0] d);
    tx_word_idx = k; tx_word_data = d; tx_word_we = 1; tick(); tx_word_we = 0; tick();
  endtask
  task automatic set_txw(input logic [10:0] v);
    tx_wptr_wdata = v; tx_wptr_we = 1; tick(); tx_wptr_we = 0; tick();
  endtask
  task automatic set_rxr(input logic [10:0] v);
    rx_rptr_wdata = v; rx_rptr_we = 1; tick(); rx_rptr_we = 0; tick();
  endtask
  task automatic clr_flags(input logic [3:0] m);
    evt_clr = m; tick(); evt_clr = 0; tick();
  endtask
  task automatic set_fill(input logic [7:0] v);
    fill_wdata = v; fill_we = 1; tick(); fill_we = 0; tick();
  endtask

  task automatic spi_start(); spi_cs_n = 0; repeat (H) tick(); endtask
  task automatic spi_stop(); repeat (H) tick(); spi_cs_n = 1; repeat (H) tick(); endtask
  task automatic spi_bits(input logic [7:0] d, input int n, output logic [7:0] q);
    q = 0;
    for (int i = 0; i < n; i++) begin
      if (!cfg_cpha) begin
        spi_mosi = d[7-i]; repeat (H) tick(); q = {q[6:0], spi_miso};
        spi_sclk = ~cfg_cpol; repeat (H) tick(); spi_sclk = cfg_cpol;
      end else begin
        spi_sclk = ~cfg_cpol; spi_mosi = d[7-i]; repeat (H) tick(); q = {q[6:0], spi_miso};
        spi_sclk = cfg_cpol; repeat (H) tick();
      end
    end
  endtask

  task automatic t_reset();
    check("R1", "tx_wptr", tx_wptr, 0); check("R1", "tx_rptr", tx_rptr, 0);
    check("R1", "rx_wptr", rx_wptr, 0); check("R1", "rx_rptr", rx_rptr, 0);
    check("R1", "enables", {tx_en, rx_en}, 0); check("R1", "flags", evt_flags, 0);
  endtask

  task automatic t_disabled();
    logic [7:0] q;
    wr_word(0, 32'h44332211); set_txw(11'd4);
    spi_start(); spi_bits(8'h3C, 8, q); spi_stop();
    check("R5", "miso while tx disabled", q, 8'hFF);
    check("R1", "fill byte reset value", q, 8'hFF);
    check("R5", "tx_rptr unmoved", tx_rptr, 0);
    check("R6", "no underrun when disabled", evt_flags[2], 0);
  endtask

  task automatic t_loop();
    logic [7:0] q;
    logic [7:0] mo [5] = '{8'hA5, 8'h3C, 8'hF0, 8'h0F, 8'h81};
    logic [7:0] ex [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    cmd(6'b010010);
    wr_word(1, 32'h88776655); set_txw(11'd8);
    spi_start();
    for (int i = 0; i < 5; i++) begin
      spi_bits(mo[i], 8, q);
      check("R4", "tx byte order", q, ex[i]);
    end
    spi_stop();
    check("R4", "tx_rptr after cpha0 prefetch", tx_rptr, 6);
    check("R2", "rx_wptr", rx_wptr, 5);
    for (int i = 0; i < 3; i++) begin
      rx_rd_addr = 10'(i); tick();
      check("R2", "rx byte", rx_rd_data, mo[i]);
    end
    rx_threshold = 11'd5; rx_level_ie = 1; tick();
    check("R8", "level irq at threshold", rx_level_irq, 1);
    set_rxr(11'd1);
    check("R12", "rx_rptr written", rx_rptr, 1);
    check("R8", "level irq below threshold", rx_level_irq, 0);
    rx_level_ie = 0;
  endtask

  task automatic t_underrun();
    logic [7:0] q;
    cmd(6'b000001);
    check("R10", "tx clear zeroes tx ptrs", {tx_wptr, tx_rptr}, 0);
    check("R10", "tx clear keeps tx_en", tx_en, 1);
    set_fill(8'h5A); clr_flags(4'hF);
    spi_start(); spi_bits(8'h00, 8, q); spi_stop();
    check("R6", "fill byte on empty", q, 8'h5A);
    check("R6", "underrun flag", evt_flags[2], 1);
    clr_flags(4'b0100);
    check("R6", "underrun cleared", evt_flags[2], 0);
  endtask

  task automatic t_modes();
    logic [7:0] q, b, d;
    logic [9:0] a;
    for (int m = 1; m < 4; m++) begin
      logic [1:0] mm = 2'(m);
      b = 8'hB1 + 8'(m * 16); d = 8'hC6 ^ 8'(m);
      cfg_cpol = mm[1]; cfg_cpha = mm[0];
      cfg_tx_lsb_first = (m == 3); cfg_rx_lsb_first = (m == 3);
      spi_sclk = cfg_cpol; repeat (H) tick();
      cmd(6'b000001); wr_word(0, {24'h0, b}); set_txw(11'd1);
      a = rx_wptr[9:0];
      spi_start(); spi_bits(d, 8, q); spi_stop();
      check("R7", "miso in mode", q, (m == 3) ? flip(b) : b);
      rx_rd_addr = a; tick();
      check("R7", "mosi in mode", rx_rd_data, (m == 3) ? flip(d) : d);
    end
    cfg_cpol = 0; cfg_cpha = 0; cfg_tx_lsb_first = 0; cfg_rx_lsb_first = 0;
    spi_sclk = 0; repeat (H) tick();
  endtask

  task automatic t_cs_flags();
    clr_flags(4'hF); evt_ie = 2'b01;
    check("R9", "flags cleared", evt_flags, 0);
    spi_start();
    check("R9", "cs assert flag", evt_flags[1:0], 2'b01);
    check("R9", "irq on assert", evt_irq, 1);
    spi_stop();
    check("R9", "cs deassert flag", evt_flags[1:0], 2'b11);
    clr_flags(4'b0001);
    check("R9", "assert cleared only", evt_flags[1:0], 2'b10);
    check("R9", "irq masked", evt_irq, 0);
    evt_ie = 2'b10; tick();
    check("R9", "irq on deassert", evt_irq, 1);
    evt_ie = 0; clr_flags(4'hF);
  endtask

  task automatic t_partial();
    logic [7:0] q;
    logic [10:0] w;
    w = rx_wptr;
    spi_start(); spi_bits(8'hF0, 4, q); spi_stop();
    check("R11", "partial byte not stored", rx_wptr, w);
    spi_start(); spi_bits(8'h96, 8, q); spi_stop();
    rx_rd_addr = w[9:0]; tick();
    check("R11", "next byte intact", rx_rd_data, 8'h96);
  endtask

  task automatic t_overflow();
    logic [7:0] q;
    logic [10:0] w;
    w = rx_wptr;
    set_rxr(w ^ 11'h400);
    check("R3", "overflow clear before", evt_flags[3], 0);
    spi_start(); spi_bits(8'h77, 8, q); spi_stop();
    check("R3", "rx_wptr held when full", rx_wptr, w);
    check("R3", "overflow flag", evt_flags[3], 1);
  endtask

  task automatic t_ctrl();
    logic [10:0] w;
    w = rx_wptr;
    cmd(6'b000001);
    check("R10", "rx ptr untouched by tx clear", rx_wptr, w);
    cmd(6'b000110);
    check("R10", "disable wins", tx_en, 0);
    cmd(6'b001000);
    check("R10", "rx clear", {rx_wptr, rx_rptr}, 0);
    check("R10", "rx still enabled", rx_en, 1);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset();
    t_disabled();
    t_loop();
    t_underrun();
    t_modes();
    t_cs_flags();
    t_partial();
    t_overflow();
    t_ctrl();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule